// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares two memory ports among fourteen clients by walking a programmable ownership table, one table per port. The external-memory region and the internal-memory region each hold 64 slot entries. Each entry names the client that owns that turn. A per-region slot pointer visits the entries in order. When the pointer reaches an entry whose owner is requesting, that owner receives the port and keeps it until it strobes done. When the owner is not requesting, the turn is forfeited: the pointer moves to the next entry one cycle later, and no other requester takes the turn.

Software shapes each client's bandwidth share by writing single table entries through a shared write port. The write port selects the region and the slot index and supplies the new owner. Owner codes at or above the client count mark an entry as empty. After reset, the external table is split evenly between the two cache clients and the internal table is entirely empty. This lets the processor caches reach external memory before any programming is done. Both regions run at the same time and never affect each other.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no requests, `ext_gnt_valid`, `int_gnt_valid`, `ext_gnt` and `int_gnt` are all zero, and both slot pointers start at slot 0.
- R2: After reset, every even external slot holds client 10 and every odd external slot holds client 11. Every internal slot holds code 15, which is empty.
- R3: When `cfg_we` is high at a clock edge, the entry `cfg_slot` of the region chosen by `cfg_region` (0 external, 1 internal) takes the value `cfg_client`. The entry is used from the next cycle on, and the other region's table is left unchanged.
- R4: When a region is idle and the owner of its current slot is a valid client whose request bit is set, then in the next cycle `gnt_valid` is 1 and `gnt_id` equals that owner.
- R5: When a region is idle and the owner of its current slot is not requesting, no grant is issued for that slot, even if other clients request. The pointer moves on one slot per cycle.
- R6: A table entry holding 14 or 15 never produces a grant, whatever the request vector holds.
- R7: A grant is held, with the same `gnt_id`, until `done` is high at a clock edge, even if the request is dropped. In the cycle after that edge `gnt_valid` is 0 and the pointer has moved to the next slot.
- R8: A `done` strobe while a region is idle has no effect on its grant outputs or on its slot timing.
- R9: The slot pointer wraps from slot 63 to slot 0. With a single owned slot, successive grants to that owner begin 64 cycles after each release.
- R10: The two regions arbitrate independently. A grant held in one region neither blocks nor delays grants in the other.
- R11: `gnt` is one-hot with bit `gnt_id` set while `gnt_valid` is 1, and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_region | input | 1 | Region to write: 0 external, 1 internal |
| cfg_slot | input | 6 | Slot index to write |
| cfg_client | input | 4 | Owner code to store (14 and 15 mean empty) |
| ext_req | input | 14 | External-region request bits, one per client |
| ext_done | input | 1 | External grant completion strobe |
| ext_gnt | output | 14 | External one-hot grant |
| ext_gnt_id | output | 4 | External granted client number |
| ext_gnt_valid | output | 1 | External grant active |
| int_req | input | 14 | Internal-region request bits, one per client |
| int_done | input | 1 | Internal grant completion strobe |
| int_gnt | output | 14 | Internal one-hot grant |
| int_gnt_id | output | 4 | Internal granted client number |
| int_gnt_valid | output | 1 | Internal grant active |

## Verification
The reset table is tried with both cache clients requesting and with only one of them requesting. This separates strict alternation from forfeited turns, in which the gap after a release is 1 cycle or 2 cycles. A third pattern adds an unowned requester, which shows that a lost slot is not stolen. A single programmed entry, with all fourteen clients requesting and empty codes written next to it, gives a 64-cycle repeat period. That period shows the pointer wrap and that empty codes never grant. Further patterns hold one region's grant while the other region runs, drop the request during a held grant, and strobe done while idle. These tell independent regions apart from shared ones, and done-based release apart from request-based release.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

  localparam int DEF_CLIENTS = 14;
  localparam int DEF_SLOTS   = 64;

  // Clients that own the external table after reset.
  localparam int CACHE_EVEN = 10;
  localparam int CACHE_ODD  = 11;

  // Reset owner of one table entry: the external region alternates the
  // two cache clients, every other region starts with empty entries.
  function automatic int reset_owner(int region, int slot, int empty_code);
    if (region == 0)
      return (slot % 2 == 0) ? CACHE_EVEN : CACHE_ODD;
    return empty_code;
  endfunction

  // An owner code grants only when it names a real client.
  function automatic bit owner_is_live(int code, int n_clients);
    return code < n_clients;
  endfunction

  // Slot after the given one, wrapping at the table end.
  function automatic int slot_after(int slot, int n_slots);
    return (slot + 1 >= n_slots) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/tdm_onehot_dec.sv
module tdm_onehot_dec #(
  parameter  int N_OUT = tdm_arb_pkg::DEF_CLIENTS,
  localparam int ID_W  = $clog2(N_OUT)
) (
  input  logic             en,
  input  logic [ID_W-1:0]  code,
  output logic [N_OUT-1:0] vec
);

  always_comb begin
    vec = '0;
    for (int i = 0; i < N_OUT; i++) begin
      vec[i] = en && (code == ID_W'(i));
    end
  end

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter  int N_CLIENTS = tdm_arb_pkg::DEF_CLIENTS,
  parameter  int N_SLOTS   = tdm_arb_pkg::DEF_SLOTS,
  parameter  int REGION    = 0,
  localparam int CID_W     = $clog2(N_CLIENTS),
  localparam int SLOT_W    = $clog2(N_SLOTS),
  localparam int EMPTY     = (1 << CID_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [CID_W-1:0]  wr_owner,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CID_W-1:0]  rd_owner
);

  logic [CID_W-1:0] entry [N_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOTS; s++) begin
        entry[s] <= CID_W'(tdm_arb_pkg::reset_owner(REGION, s, EMPTY));
      end
    end else if (wr_en) begin
      entry[wr_slot] <= wr_owner;
    end
  end

  assign rd_owner = entry[rd_slot];

endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine #(
  parameter  int N_CLIENTS = tdm_arb_pkg::DEF_CLIENTS,
  parameter  int N_SLOTS   = tdm_arb_pkg::DEF_SLOTS,
  localparam int CID_W     = $clog2(N_CLIENTS),
  localparam int SLOT_W    = $clog2(N_SLOTS),
  localparam int CODE_SPAN = 1 << CID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CLIENTS-1:0] req,
  input  logic                 done,
  input  logic [CID_W-1:0]     owner,
  output logic [SLOT_W-1:0]    slot_ptr,
  output logic                 gnt_valid,
  output logic [CID_W-1:0]     gnt_id,
  output logic [N_CLIENTS-1:0] gnt
);

  // Request vector widened to cover every owner code, so that the
  // empty codes index a zero bit.
  logic [CODE_SPAN-1:0] req_wide;
  logic                 owner_live;
  logic                 ev_take;
  logic                 ev_forfeit;
  logic                 ev_release;
  logic [SLOT_W-1:0]    slot_next;

  assign req_wide   = CODE_SPAN'(req);
  assign owner_live = tdm_arb_pkg::owner_is_live(int'(owner), N_CLIENTS);
  assign ev_take    = !gnt_valid && owner_live && req_wide[owner];
  assign ev_forfeit = !gnt_valid && !ev_take;
  assign ev_release = gnt_valid && done;
  assign slot_next  = SLOT_W'(tdm_arb_pkg::slot_after(int'(slot_ptr), N_SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_ptr  <= '0;
      gnt_valid <= 1'b0;
      gnt_id    <= '0;
    end else if (ev_take) begin
      gnt_valid <= 1'b1;
      gnt_id    <= owner;
    end else if (ev_forfeit || ev_release) begin
      gnt_valid <= 1'b0;
      slot_ptr  <= slot_next;
    end
  end

  tdm_onehot_dec #(.N_OUT(N_CLIENTS)) u_dec (
    .en   (gnt_valid),
    .code (gnt_id),
    .vec  (gnt)
  );

endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
  parameter  int N_CLIENTS = tdm_arb_pkg::DEF_CLIENTS,
  parameter  int N_SLOTS   = tdm_arb_pkg::DEF_SLOTS,
  localparam int CID_W     = $clog2(N_CLIENTS),
  localparam int SLOT_W    = $clog2(N_SLOTS),
  localparam int N_REGIONS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_region,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [CID_W-1:0]     cfg_client,
  input  logic [N_CLIENTS-1:0] ext_req,
  input  logic                 ext_done,
  output logic [N_CLIENTS-1:0] ext_gnt,
  output logic [CID_W-1:0]     ext_gnt_id,
  output logic                 ext_gnt_valid,
  input  logic [N_CLIENTS-1:0] int_req,
  input  logic                 int_done,
  output logic [N_CLIENTS-1:0] int_gnt,
  output logic [CID_W-1:0]     int_gnt_id,
  output logic                 int_gnt_valid
);

  // Region 0 is external memory, region 1 is internal memory.
  logic [N_CLIENTS-1:0] rg_req   [N_REGIONS];
  logic                 rg_done  [N_REGIONS];
  logic [N_CLIENTS-1:0] rg_gnt   [N_REGIONS];
  logic [CID_W-1:0]     rg_id    [N_REGIONS];
  logic                 rg_valid [N_REGIONS];

  assign rg_req[0]     = ext_req;
  assign rg_req[1]     = int_req;
  assign rg_done[0]    = ext_done;
  assign rg_done[1]    = int_done;
  assign ext_gnt       = rg_gnt[0];
  assign int_gnt       = rg_gnt[1];
  assign ext_gnt_id    = rg_id[0];
  assign int_gnt_id    = rg_id[1];
  assign ext_gnt_valid = rg_valid[0];
  assign int_gnt_valid = rg_valid[1];

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
    logic [CID_W-1:0]  cur_owner;
    logic [SLOT_W-1:0] cur_slot;
    logic              wr_here;

    assign wr_here = cfg_we && (cfg_region == 1'(r));

    tdm_slot_table #(
      .N_CLIENTS (N_CLIENTS),
      .N_SLOTS   (N_SLOTS),
      .REGION    (r)
    ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_here),
      .wr_slot  (cfg_slot),
      .wr_owner (cfg_client),
      .rd_slot  (cur_slot),
      .rd_owner (cur_owner)
    );

    tdm_slot_engine #(
      .N_CLIENTS (N_CLIENTS),
      .N_SLOTS   (N_SLOTS)
    ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (rg_req[r]),
      .done      (rg_done[r]),
      .owner     (cur_owner),
      .slot_ptr  (cur_slot),
      .gnt_valid (rg_valid[r]),
      .gnt_id    (rg_id[r]),
      .gnt       (rg_gnt[r])
    );
  end

endmodule

// File: rtl/tdm_engine_chk.sv
module tdm_engine_chk #(
  parameter  int N_CLIENTS = tdm_arb_pkg::DEF_CLIENTS,
  parameter  int N_SLOTS   = tdm_arb_pkg::DEF_SLOTS,
  localparam int CID_W     = $clog2(N_CLIENTS),
  localparam int SLOT_W    = $clog2(N_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic [CID_W-1:0]     owner,
  input logic [SLOT_W-1:0]    slot_ptr,
  input logic                 gnt_valid,
  input logic [CID_W-1:0]     gnt_id,
  input logic [N_CLIENTS-1:0] gnt,
  input logic                 ev_take,
  input logic                 ev_forfeit
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  // R4: a taken slot becomes a grant to the slot owner.
  a_r4_take_grants_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> gnt_valid && gnt_id == $past(owner));

  // R5: a forfeited slot grants nothing and steps the pointer by one.
  a_r5_forfeit_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_forfeit && slot_ptr != LAST_SLOT) |=>
      !gnt_valid && slot_ptr == $past(slot_ptr) + 1'b1);

  // R6: empty owner codes never lead to a grant.
  a_r6_empty_never_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && int'(owner) >= N_CLIENTS) |=> !gnt_valid);

  // R7: without done the grant and its slot are held.
  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !done) |=> gnt_valid && $stable(gnt_id) && $stable(slot_ptr));

  // R7: done ends the grant.
  a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && done) |=> !gnt_valid);

  // R9: leaving the last slot returns to slot 0.
  a_r9_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_forfeit || (gnt_valid && done)) && slot_ptr == LAST_SLOT) |=> slot_ptr == '0);

  // R11: one-hot grant that agrees with the granted number.
  a_r11_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (gnt_valid == (gnt != '0)));

  a_r11_grant_bit_matches: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt[gnt_id]);

endmodule

bind tdm_slot_engine tdm_engine_chk #(
  .N_CLIENTS (N_CLIENTS),
  .N_SLOTS   (N_SLOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .owner      (owner),
  .slot_ptr   (slot_ptr),
  .gnt_valid  (gnt_valid),
  .gnt_id     (gnt_id),
  .gnt        (gnt),
  .ev_take    (ev_take),
  .ev_forfeit (ev_forfeit)
);

// File: tb/tb_tdm_slot_arbiter.sv
module tb_tdm_slot_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_region = 1'b0;
  logic [5:0]  cfg_slot = '0;
  logic [3:0]  cfg_client = '0;
  logic [13:0] ext_req = '0;
  logic        ext_done = 1'b0;
  logic [13:0] ext_gnt;
  logic [3:0]  ext_gnt_id;
  logic        ext_gnt_valid;
  logic [13:0] int_req = '0;
  logic        int_done = 1'b0;
  logic [13:0] int_gnt;
  logic [3:0]  int_gnt_id;
  logic        int_gnt_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tdm_slot_arbiter dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic rv(input bit r);
    return r ? int_gnt_valid : ext_gnt_valid;
  endfunction

  function automatic int rid(input bit r);
    return r ? int'(int_gnt_id) : int'(ext_gnt_id);
  endfunction

  function automatic logic [13:0] rgnt(input bit r);
    return r ? int_gnt : ext_gnt;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; ext_req = '0; int_req = '0;
    ext_done = 1'b0; int_done = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic tbl_write(input bit r, input int slot, input int code);
    cfg_we = 1'b1; cfg_region = r; cfg_slot = 6'(slot); cfg_client = 4'(code);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic release_gnt(input bit r);
    if (r) int_done = 1'b1; else ext_done = 1'b1;
    tick();
    int_done = 1'b0; ext_done = 1'b0;
    check(rv(r) == 1'b0, "R7 grant drops after done", int'(rv(r)), 0);
  endtask

  // Cycles from now until a grant is seen in region r (limit+1 if none).
  task automatic wait_grant(input bit r, input int limit, output int cnt);
    cnt = 0;
    do begin
      tick();
      cnt++;
    end while (!rv(r) && cnt <= limit);
    if (rv(r))
      check(rgnt(r) == 14'(1 << rid(r)), "R11 one-hot matches id", int'(rgnt(r)), 1 << rid(r));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ext_req = '1; int_req = '1;
    tick(2);
    check(!ext_gnt_valid && !int_gnt_valid, "R1 no grant in reset",
          int'(ext_gnt_valid) + int'(int_gnt_valid), 0);
    check(ext_gnt == '0 && int_gnt == '0, "R1 grant vectors zero in reset",
          int'(ext_gnt | int_gnt), 0);
    do_reset();
    tick();
    check(!ext_gnt_valid && !int_gnt_valid, "R1 idle after reset",
          int'(ext_gnt_valid) + int'(int_gnt_valid), 0);
  endtask

  task automatic t_default_alternate();
    int cnt;
    do_reset();
    ext_req = 14'((1 << 10) | (1 << 11));
    tick();
    check(ext_gnt_valid && ext_gnt_id == 4'd10, "R2 slot 0 owner 10", int'(ext_gnt_id), 10);
    check(ext_gnt == 14'(1 << 10), "R11 one-hot for 10", int'(ext_gnt), 1 << 10);
    for (int k = 0; k < 4; k++) begin
      release_gnt(1'b0);
      wait_grant(1'b0, 5, cnt);
      check(cnt == 1, "R4 next slot granted after 1 cycle", cnt, 1);
      check(rid(0) == ((k % 2 == 0) ? 11 : 10), "R2 alternating owners", rid(0),
            (k % 2 == 0) ? 11 : 10);
    end
    release_gnt(1'b0);
  endtask

  task automatic t_no_steal();
    int cnt;
    do_reset();
    ext_req = 14'((1 << 11) | (1 << 3));
    tick();
    check(!ext_gnt_valid, "R5 slot 0 lost, client 3 not granted", int'(ext_gnt_valid), 0);
    tick();
    check(ext_gnt_valid && ext_gnt_id == 4'd11, "R5 slot 1 owner 11", int'(ext_gnt_id), 11);
    release_gnt(1'b0);
    wait_grant(1'b0, 10, cnt);
    check(cnt == 2 && ext_gnt_id == 4'd11, "R5 gap of one lost slot", cnt, 2);
    release_gnt(1'b0);
  endtask

  task automatic t_hold();
    bit held = 1;
    do_reset();
    ext_req = 14'(1 << 10);
    tick();
    ext_req = '0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!ext_gnt_valid || ext_gnt_id != 4'd10) held = 0;
    end
    check(held, "R7 grant held with request dropped", int'(held), 1);
    release_gnt(1'b0);
    tick(3);
    check(!ext_gnt_valid, "R7 no regrant without request", int'(ext_gnt_valid), 0);
  endtask

  task automatic t_done_idle();
    int cnt;
    bit quiet = 1;
    do_reset();
    ext_done = 1'b1; int_done = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (ext_gnt_valid || int_gnt_valid) quiet = 0;
    end
    check(quiet, "R8 done while idle gives no grant", int'(quiet), 1);
    ext_done = 1'b0; int_done = 1'b0;
    ext_req = 14'(1 << 10);
    wait_grant(1'b0, 4, cnt);
    check(ext_gnt_valid && ext_gnt_id == 4'd10, "R8 grant after idle done", int'(ext_gnt_id), 10);
    release_gnt(1'b0);
    ext_done = 1'b1;
    tick();
    ext_done = 1'b0;
    check(!ext_gnt_valid, "R8 idle done in gap", int'(ext_gnt_valid), 0);
    tick();
    check(ext_gnt_valid && ext_gnt_id == 4'd10, "R8 slot timing unchanged", int'(ext_gnt_valid), 1);
    release_gnt(1'b0);
  endtask

  task automatic t_int_program();
    int cnt;
    do_reset();
    tbl_write(1'b1, 5, 3);
    tbl_write(1'b1, 6, 14);
    tbl_write(1'b1, 7, 15);
    int_req = '1;
    wait_grant(1'b1, 70, cnt);
    check(int_gnt_valid && int_gnt_id == 4'd3, "R3 written owner granted", int'(int_gnt_id), 3);
    release_gnt(1'b1);
    wait_grant(1'b1, 70, cnt);
    check(cnt == 64, "R9 R6 one owned slot repeats every 64", cnt, 64);
    check(int_gnt_id == 4'd3, "R6 empty codes skipped", int'(int_gnt_id), 3);
    check(!ext_gnt_valid, "R10 external idle", int'(ext_gnt_valid), 0);
    release_gnt(1'b1);
  endtask

  task automatic t_ext_rewrite();
    int cnt;
    bit quiet = 1;
    do_reset();
    tbl_write(1'b0, 2, 4);
    ext_req = 14'(1 << 4);
    int_req = '1;
    wait_grant(1'b0, 70, cnt);
    check(ext_gnt_valid && ext_gnt_id == 4'd4, "R3 external entry rewritten", int'(ext_gnt_id), 4);
    release_gnt(1'b0);
    for (int i = 0; i < 63; i++) begin
      tick();
      if (ext_gnt_valid || int_gnt_valid) quiet = 0;
    end
    check(quiet, "R2 R3 internal empty and external single owner", int'(quiet), 1);
    tick();
    check(ext_gnt_valid && ext_gnt_id == 4'd4, "R9 wrap back to slot 2", int'(ext_gnt_valid), 1);
    release_gnt(1'b0);
  endtask

  task automatic t_independent();
    int cnt;
    bit ext_held = 1;
    do_reset();
    tbl_write(1'b1, 9, 2);
    ext_req = 14'(1 << 10);
    int_req = 14'(1 << 2);
    wait_grant(1'b0, 4, cnt);
    check(ext_gnt_id == 4'd10, "R10 external grant taken", int'(ext_gnt_id), 10);
    cnt = 0;
    while (!int_gnt_valid && cnt < 70) begin
      tick();
      cnt++;
      if (!ext_gnt_valid || ext_gnt_id != 4'd10) ext_held = 0;
    end
    check(int_gnt_valid && int_gnt_id == 4'd2, "R10 internal grants while external held",
          int'(int_gnt_id), 2);
    release_gnt(1'b1);
    check(ext_held && ext_gnt_valid && ext_gnt_id == 4'd10, "R10 external unaffected",
          int'(ext_gnt_valid), 1);
    release_gnt(1'b0);
  endtask

  initial begin
    tick();
    t_reset();
    t_default_alternate();
    t_no_steal();
    t_hold();
    t_done_idle();
    t_int_program();
    t_ext_rewrite();
    t_independent();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule